// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block orders the two control lines of a flat panel so that the panel's contrast supply never sees power without a settled controller behind it. A power-up request first raises the controller enable. After a fixed settling interval, it raises panel power. A power-down request reverses this: panel power drops at once, the same interval elapses, and only then is the enable released. The interval is counted in pulses of an external millisecond strobe, so the block needs no knowledge of its own clock frequency.

Requests arrive as single-cycle pulses. A busy flag covers each sequence from the cycle after acceptance to its completion, and the block ignores a further power-up request during that time. A power-down request that arrives while power-up is still settling is the one exception. It aborts the power-up without ever raising panel power, but it still waits the full interval before the enable drops. An interrupt-enable output marks the fully powered state, so frame interrupts are only armed while the panel is actually being driven.

Top module: `panel_pwr_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, ctl_en_o, panel_pwr_o, busy_o and frm_irq_en_o are all 0. A reset in the middle of a sequence returns the block to the off state.
- R2: A pulse on up_req_i while the block is off sets ctl_en_o=1, busy_o=1 and panel_pwr_o=0 from the next cycle.
- R3: Panel power rises in the cycle after the DELAY_TICKS-th tick_i pulse that follows acceptance, and busy_o falls in that same cycle. A tick in the cycle of acceptance is not counted. The default DELAY_TICKS is 20, which is 20 ms at a 1 kHz strobe.
- R4: frm_irq_en_o is 1 exactly when ctl_en_o=1, panel_pwr_o=1 and busy_o=0.
- R5: A pulse on down_req_i while fully on sets panel_pwr_o=0 from the next cycle while ctl_en_o and busy_o stay 1. After DELAY_TICKS further ticks, ctl_en_o and busy_o return to 0.
- R6: The block ignores up_req_i unless it is off. It ignores down_req_i while off and while powering down, and a power-down that is already running is not restarted.
- R7: A pulse on down_req_i during the power-up settling interval starts power-down with a fresh count. panel_pwr_o stays 0 throughout, and ctl_en_o drops after DELAY_TICKS ticks.
- R8: panel_pwr_o is never 1 while ctl_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_i | input | 1 | Power-up request pulse |
| down_req_i | input | 1 | Power-down request pulse |
| tick_i | input | 1 | Millisecond strobe, one cycle wide |
| ctl_en_o | output | 1 | Controller enable |
| panel_pwr_o | output | 1 | Panel power |
| busy_o | output | 1 | Sequence in progress |
| frm_irq_en_o | output | 1 | Frame interrupt enable |

## Verification
The checker watches, on every cycle, the ordering rules that never depend on the count. Power never appears without enable, and the interrupt enable tracks the fully-on condition. Each edge of enable or power appears together with the right companion values. The outputs hold still during a settling interval unless a tick or an abort arrives, and the block leaves the off state only on a request. The exact tick on which power rises or enable falls can only be shown by the bench's scenarios, because it depends on the parameterised count. The same holds for which request pulses are ignored, for the abort path during power-up and for a reset taken mid-sequence.

// File: rtl/panel_pwr_seq_pkg.sv
package panel_pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RAISE = 2'd1,
        ST_ON    = 2'd2,
        ST_LOWER = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } fsm_regs_t;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int DELAY_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW   = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
    localparam int LAST = DELAY_TICKS - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart_i) begin
            r_d.cnt = '0;
        end else if (tick_i && (r_q.cnt != CW'(LAST))) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = tick_i && !restart_i && (r_q.cnt == CW'(LAST));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import panel_pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_req_i,
    input  logic       down_req_i,
    input  logic       done_i,
    output logic       restart_o,
    output seq_state_e state_o
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        restart_o = 1'b0;
        unique case (r_q.state)
            ST_OFF: begin
                if (up_req_i) begin
                    r_d.state = ST_RAISE;
                    restart_o = 1'b1;
                end
            end
            ST_RAISE: begin
                if (down_req_i) begin
                    r_d.state = ST_LOWER;
                    restart_o = 1'b1;
                end else if (done_i) begin
                    r_d.state = ST_ON;
                end
            end
            ST_ON: begin
                if (down_req_i) begin
                    r_d.state = ST_LOWER;
                    restart_o = 1'b1;
                end
            end
            ST_LOWER: begin
                if (done_i) begin
                    r_d.state = ST_OFF;
                end
            end
            default: r_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import panel_pwr_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req_i,
    input  logic down_req_i,
    input  logic tick_i,
    output logic ctl_en_o,
    output logic panel_pwr_o,
    output logic busy_o,
    output logic frm_irq_en_o
);
    seq_state_e state;
    logic       restart;
    logic       done;

    seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_req_i   (up_req_i),
        .down_req_i (down_req_i),
        .done_i     (done),
        .restart_o  (restart),
        .state_o    (state)
    );

    settle_timer #(
        .DELAY_TICKS (DELAY_TICKS)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_i    (tick_i),
        .done_o    (done)
    );

    assign ctl_en_o     = (state != ST_OFF);
    assign panel_pwr_o  = (state == ST_ON);
    assign busy_o       = (state == ST_RAISE) || (state == ST_LOWER);
    assign frm_irq_en_o = (state == ST_ON);

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic up_req_i,
    input logic down_req_i,
    input logic tick_i,
    input logic ctl_en_o,
    input logic panel_pwr_o,
    input logic busy_o,
    input logic frm_irq_en_o
);
    // R8
    pwr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_pwr_o |-> ctl_en_o);

    // R4
    irq_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_irq_en_o == (ctl_en_o && panel_pwr_o && !busy_o));

    // R2
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_en_o) |-> (busy_o && !panel_pwr_o));

    // R5
    pwr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_pwr_o) |-> (ctl_en_o && busy_o));

    // R3
    pwr_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !panel_pwr_o && !tick_i && !down_req_i) |=>
            ($stable(ctl_en_o) && $stable(panel_pwr_o)));

    // R6
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en_o && !up_req_i) |=> !ctl_en_o);

endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_i     (up_req_i),
    .down_req_i   (down_req_i),
    .tick_i       (tick_i),
    .ctl_en_o     (ctl_en_o),
    .panel_pwr_o  (panel_pwr_o),
    .busy_o       (busy_o),
    .frm_irq_en_o (frm_irq_en_o)
);

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0;
    logic down_req = 1'b0;
    logic tick = 1'b0;
    logic en, pwr, busy, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    panel_pwr_seq #(.DELAY_TICKS(N)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_req_i     (up_req),
        .down_req_i   (down_req),
        .tick_i       (tick),
        .ctl_en_o     (en),
        .panel_pwr_o  (pwr),
        .busy_o       (busy),
        .frm_irq_en_o (irq)
    );

    task automatic expect_out(input string tag, input logic e_en, input logic e_pwr,
                              input logic e_busy, input logic e_irq);
        checks++;
        if ({en, pwr, busy, irq} !== {e_en, e_pwr, e_busy, e_irq}) begin
            errors++;
            $display("FAIL %s: en/pwr/busy/irq actual=%b%b%b%b expected=%b%b%b%b",
                     tag, en, pwr, busy, irq, e_en, e_pwr, e_busy, e_irq);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic pulse_up();
        @(negedge clk) up_req = 1'b1;
        @(negedge clk) up_req = 1'b0;
    endtask

    task automatic pulse_down();
        @(negedge clk) down_req = 1'b1;
        @(negedge clk) down_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 0, 0, 0, 0);
    endtask

    // R2 R3 R4: power-up, with a tick in the acceptance cycle not counted
    task automatic test_power_up();
        @(negedge clk) begin up_req = 1'b1; tick = 1'b1; end
        @(negedge clk) begin up_req = 1'b0; tick = 1'b0; end
        expect_out("R2 enable first", 1, 0, 1, 0);
        for (int i = 0; i < N - 1; i++) begin
            pulse_tick();
            if (pwr !== 1'b0) begin
                checks++; errors++;
                $display("FAIL R3 early power at tick %0d: actual=%b expected=0", i + 1, pwr);
            end
        end
        expect_out("R3 before last tick", 1, 0, 1, 0);
        pulse_tick();
        expect_out("R3 R4 power on", 1, 1, 0, 1);
    endtask

    // R6: requests that must be ignored
    task automatic test_ignored_when_on();
        pulse_up();
        repeat (3) pulse_tick();
        expect_out("R6 up_req in on state", 1, 1, 0, 1);
    endtask

    // R5 R6: power-down, with a second down request during the interval
    task automatic test_power_down();
        pulse_down();
        expect_out("R5 power first", 1, 0, 1, 0);
        for (int i = 0; i < N - 1; i++) begin
            pulse_tick();
            if (i == 9) pulse_down();
            if (i == 10) pulse_up();
        end
        expect_out("R5 R6 enable held until last tick", 1, 0, 1, 0);
        pulse_tick();
        expect_out("R5 all off", 0, 0, 0, 0);
    endtask

    task automatic test_ignored_when_off();
        pulse_down();
        repeat (3) pulse_tick();
        expect_out("R6 down_req in off state", 0, 0, 0, 0);
    endtask

    // R7: abort during power-up settling
    task automatic test_abort();
        pulse_up();
        repeat (5) pulse_tick();
        expect_out("R7 settling", 1, 0, 1, 0);
        pulse_down();
        expect_out("R7 abort accepted", 1, 0, 1, 0);
        for (int i = 0; i < N - 1; i++) begin
            pulse_tick();
            if (pwr !== 1'b0) begin
                checks++; errors++;
                $display("FAIL R7 power rose during abort: actual=%b expected=0", pwr);
            end
        end
        expect_out("R7 fresh count held", 1, 0, 1, 0);
        pulse_tick();
        expect_out("R7 abort complete", 0, 0, 0, 0);
    endtask

    // R1: reset in mid-sequence
    task automatic test_mid_reset();
        pulse_up();
        repeat (3) pulse_tick();
        expect_out("R1 pre-reset settling", 1, 0, 1, 0);
        do_reset();
        repeat (N) pulse_tick();
        expect_out("R1 stays off after reset", 0, 0, 0, 0);
    endtask

    initial begin
        do_reset();
        test_power_up();
        test_ignored_when_on();
        test_power_down();
        test_ignored_when_off();
        test_abort();
        test_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule